// File: doc/BRIEF.md
# Interrupt Pending Eligibility Bank

This block keeps the per-line state of a bank of interrupt lines (32 by default). For each line it holds a pending latch, a trigger-mode bit, an enable bit, an active bit, a group bit and a group-modifier bit. It also samples the live level of every interrupt input. From this state it produces one registered mask each cycle. A set bit in the mask means that line may be offered to the CPU-side priority logic.

A line is raw-pending when its latch is set, or when it is level-triggered and its input is high. It is eligible when it is raw-pending, enabled and not active, and when the global enable for its security group is on. Groups are resolved from the group bit and the modifier bit. A security-off control makes every modifier read as zero. Every state register has a pair of per-line set and clear pulse vectors. When both pulses hit the same bit in the same cycle, the set takes effect.

The eligibility mask is a plain status vector with no handshake. Consumers sample it every cycle, so there is no back-pressure. All control pins are plain levels or single-cycle pulses.

Top module: `ipe_bank`

## Requirements
- R1: While reset is asserted, every state bit is cleared and the mask reads all zeros. Cleared means level-triggered, disabled, not active, group bit 0 and modifier 0.
- R2: A line whose trigger bit is 0 (level) and whose input is high is raw-pending. It stops being raw-pending when the input goes low, and nothing is latched.
- R3: A line whose trigger bit is 1 (edge) latches pending when its input goes from 0 to 1. The latch stays set after the input falls.
- R4: A clear-pending pulse clears the pending latch. If a set-pending pulse or a rising edge arrives for the same bit in the same cycle, the latch ends up set.
- R5: A raw-pending line contributes to the mask only while its enable bit is 1.
- R6: A line whose active bit is 1 is never in the mask.
- R7: A line with group bit 1 passes only while the group-1 non-secure enable is high.
- R8: A line with group bit 0 and modifier 1 passes only while the group-1 secure enable is high.
- R9: A line with group bit 0 and modifier 0 passes only while the group-0 enable is high.
- R10: While the security-off control is high, every modifier bit is treated as 0, so group-0 lines follow the group-0 enable alone. The stored modifier bits are kept.
- R11: The mask is registered. After a clock edge it shows the result computed from the state and inputs present just before that edge, across all lines at once.
- R12: For the trigger, enable, active, group and modifier registers, a set pulse and a clear pulse on the same bit in the same cycle leave the bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lvl_i | input | N | Live interrupt input levels |
| pend_set_i | input | N | Set-pending pulses |
| pend_clr_i | input | N | Clear-pending pulses |
| edge_set_i | input | N | Select edge trigger |
| edge_clr_i | input | N | Select level trigger |
| en_set_i | input | N | Enable pulses |
| en_clr_i | input | N | Disable pulses |
| act_set_i | input | N | Mark active pulses |
| act_clr_i | input | N | Clear active pulses |
| grp_set_i | input | N | Set group bit pulses |
| grp_clr_i | input | N | Clear group bit pulses |
| mod_set_i | input | N | Set modifier bit pulses |
| mod_clr_i | input | N | Clear modifier bit pulses |
| g0_en_i | input | 1 | Group-0 global enable |
| g1s_en_i | input | 1 | Group-1 secure global enable |
| g1ns_en_i | input | 1 | Group-1 non-secure global enable |
| sec_off_i | input | 1 | Security off: modifiers read as zero |
| elig_o | output | N | Registered eligibility mask |

## Verification
Changes to a level input or a global control show up in the mask after one clock edge. Set and clear pulses, and input edges, first update a state register at one edge, so their effect on the mask appears one edge after that. The bench drives each cycle's inputs on the falling edge. It then computes the expected mask from its own state model as that model stood before the rising edge, and only afterwards advances the model. It compares the mask on the next falling edge, which covers both delays without counting them case by case.

// File: rtl/ipe_pkg.sv
package ipe_pkg;

  typedef struct packed {
    logic g0_en;
    logic g1s_en;
    logic g1ns_en;
    logic sec_off;
  } ipe_ctrl_t;

  localparam int unsigned IPE_NUM_REGS = 5;

endpackage

// File: rtl/ipe_setclr_reg.sv
module ipe_setclr_reg #(
  parameter int unsigned N        = 32,
  parameter bit          SET_WINS = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  logic [N-1:0] nxt;

  generate
    if (SET_WINS) begin : g_set_wins
      always_comb nxt = set_i | (q_o & ~clr_i);
    end else begin : g_clr_wins
      always_comb nxt = (set_i | q_o) & ~clr_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt;
  end

endmodule

// File: rtl/ipe_pend_latch.sv
module ipe_pend_latch #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] lvl_d;
  logic [N-1:0] rise;

  // rising edge only counts on lines configured for edge trigger
  always_comb rise = lvl_i & ~lvl_d & edge_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '0;
    else        lvl_d <= lvl_i;
  end

  ipe_setclr_reg #(.N(N), .SET_WINS(1'b1)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (set_i | rise),
    .clr_i (clr_i),
    .q_o   (pend_o)
  );

endmodule

// File: rtl/ipe_elig_calc.sv
module ipe_elig_calc
  import ipe_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic [N-1:0] pend_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] lvl_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] act_i,
  input  logic [N-1:0] grp_i,
  input  logic [N-1:0] mod_i,
  input  ipe_ctrl_t    ctrl_i,
  output logic [N-1:0] elig_o
);

  logic [N-1:0] raw;
  logic [N-1:0] live;
  logic [N-1:0] mod_eff;
  logic [N-1:0] pass_g1ns;
  logic [N-1:0] pass_g1s;
  logic [N-1:0] pass_g0;

  always_comb begin
    raw       = pend_i | (~edge_i & lvl_i);
    live      = raw & en_i & ~act_i;
    mod_eff   = ctrl_i.sec_off ? '0 : mod_i;
    pass_g1ns = ctrl_i.g1ns_en ? grp_i : '0;
    pass_g1s  = ctrl_i.g1s_en ? (~grp_i & mod_eff) : '0;
    pass_g0   = ctrl_i.g0_en ? (~grp_i & ~mod_eff) : '0;
    elig_o    = live & (pass_g1ns | pass_g1s | pass_g0);
  end

endmodule

// File: rtl/ipe_bank.sv
module ipe_bank
  import ipe_pkg::*;
#(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_lvl_i,
  input  logic [N-1:0] pend_set_i,
  input  logic [N-1:0] pend_clr_i,
  input  logic [N-1:0] edge_set_i,
  input  logic [N-1:0] edge_clr_i,
  input  logic [N-1:0] en_set_i,
  input  logic [N-1:0] en_clr_i,
  input  logic [N-1:0] act_set_i,
  input  logic [N-1:0] act_clr_i,
  input  logic [N-1:0] grp_set_i,
  input  logic [N-1:0] grp_clr_i,
  input  logic [N-1:0] mod_set_i,
  input  logic [N-1:0] mod_clr_i,
  input  logic         g0_en_i,
  input  logic         g1s_en_i,
  input  logic         g1ns_en_i,
  input  logic         sec_off_i,
  output logic [N-1:0] elig_o
);

  localparam int unsigned NR = IPE_NUM_REGS;

  logic [NR-1:0][N-1:0] cfg_set;
  logic [NR-1:0][N-1:0] cfg_clr;
  logic [NR-1:0][N-1:0] cfg_q;

  logic [N-1:0] pend_q, edge_q, en_q, act_q, grp_q, mod_q;
  logic [N-1:0] elig_d;
  ipe_ctrl_t    ctrl;

  // order of configuration registers: trigger, enable, active, group, modifier
  always_comb begin
    cfg_set[0] = edge_set_i; cfg_clr[0] = edge_clr_i;
    cfg_set[1] = en_set_i;   cfg_clr[1] = en_clr_i;
    cfg_set[2] = act_set_i;  cfg_clr[2] = act_clr_i;
    cfg_set[3] = grp_set_i;  cfg_clr[3] = grp_clr_i;
    cfg_set[4] = mod_set_i;  cfg_clr[4] = mod_clr_i;
  end

  generate
    for (genvar r = 0; r < NR; r++) begin : g_cfg
      ipe_setclr_reg #(.N(N), .SET_WINS(1'b1)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (cfg_set[r]),
        .clr_i (cfg_clr[r]),
        .q_o   (cfg_q[r])
      );
    end
  endgenerate

  always_comb begin
    edge_q = cfg_q[0];
    en_q   = cfg_q[1];
    act_q  = cfg_q[2];
    grp_q  = cfg_q[3];
    mod_q  = cfg_q[4];
    ctrl   = '{g0_en: g0_en_i, g1s_en: g1s_en_i, g1ns_en: g1ns_en_i, sec_off: sec_off_i};
  end

  ipe_pend_latch #(.N(N)) u_pend (
    .clk         (clk),
    .rst_n       (rst_n),
    .lvl_i       (irq_lvl_i),
    .edge_mode_i (edge_q),
    .set_i       (pend_set_i),
    .clr_i       (pend_clr_i),
    .pend_o      (pend_q)
  );

  ipe_elig_calc #(.N(N)) u_calc (
    .pend_i (pend_q),
    .edge_i (edge_q),
    .lvl_i  (irq_lvl_i),
    .en_i   (en_q),
    .act_i  (act_q),
    .grp_i  (grp_q),
    .mod_i  (mod_q),
    .ctrl_i (ctrl),
    .elig_o (elig_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) elig_o <= '0;
    else        elig_o <= elig_d;
  end

endmodule

// File: rtl/ipe_bank_chk.sv
module ipe_bank_chk #(
  parameter int unsigned N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] pend_set_i,
  input logic [N-1:0] en_set_i,
  input logic [N-1:0] en_clr_i,
  input logic         g0_en_i,
  input logic         g1ns_en_i,
  input logic         sec_off_i,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] en_q,
  input logic [N-1:0] act_q,
  input logic [N-1:0] grp_q,
  input logic [N-1:0] mod_q,
  input logic [N-1:0] elig_o
);

  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |=> (elig_o == '0));

  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & $past(pend_set_i)) == $past(pend_set_i)));

  a_r5_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_o & ~$past(en_q)) == '0));

  a_r6_active_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((elig_o & $past(act_q)) == '0));

  a_r7_g1ns_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(g1ns_en_i) |-> ((elig_o & $past(grp_q)) == '0));

  a_r9_g0_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(g0_en_i) |->
      ((elig_o & ~$past(grp_q) & ~($past(mod_q) & {N{~$past(sec_off_i)}})) == '0));

  a_r12_enable_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & $past(en_set_i & en_clr_i)) == $past(en_set_i & en_clr_i)));

endmodule

bind ipe_bank ipe_bank_chk #(.N(N)) u_ipe_bank_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pend_set_i (pend_set_i),
  .en_set_i   (en_set_i),
  .en_clr_i   (en_clr_i),
  .g0_en_i    (g0_en_i),
  .g1ns_en_i  (g1ns_en_i),
  .sec_off_i  (sec_off_i),
  .pend_q     (pend_q),
  .en_q       (en_q),
  .act_q      (act_q),
  .grp_q      (grp_q),
  .mod_q      (mod_q),
  .elig_o     (elig_o)
);

// File: tb/test_ipe_bank.sv
module test_ipe_bank;

  localparam int N = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] lvl = '0;
  logic [N-1:0] ps = '0, pc = '0, es = '0, ec = '0, ns = '0, nc = '0;
  logic [N-1:0] as_ = '0, ac = '0, gs = '0, gc = '0, ms = '0, mc = '0;
  logic g0 = 1'b0, g1s = 1'b0, g1ns = 1'b0, soff = 1'b0;
  logic [N-1:0] elig;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model state
  logic [N-1:0] m_pend = '0, m_edge = '0, m_en = '0, m_act = '0, m_grp = '0, m_mod = '0, m_prev = '0;

  always #5 clk = ~clk;

  ipe_bank #(.N(N)) i_ipe_bank (
    .clk(clk), .rst_n(rst_n), .irq_lvl_i(lvl),
    .pend_set_i(ps), .pend_clr_i(pc), .edge_set_i(es), .edge_clr_i(ec),
    .en_set_i(ns), .en_clr_i(nc), .act_set_i(as_), .act_clr_i(ac),
    .grp_set_i(gs), .grp_clr_i(gc), .mod_set_i(ms), .mod_clr_i(mc),
    .g0_en_i(g0), .g1s_en_i(g1s), .g1ns_en_i(g1ns), .sec_off_i(soff),
    .elig_o(elig)
  );

  function automatic logic [N-1:0] expect_mask();
    logic [N-1:0] raw, modv, gm;
    raw  = (m_pend | (~m_edge & lvl)) & m_en & ~m_act;
    modv = soff ? '0 : m_mod;
    gm   = '0;
    if (g1ns) gm = gm | m_grp;
    if (g1s)  gm = gm | (~m_grp & modv);
    if (g0)   gm = gm | (~m_grp & ~modv);
    return raw & gm;
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: elig=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_pulses();
    ps = '0; pc = '0; es = '0; ec = '0; ns = '0; nc = '0;
    as_ = '0; ac = '0; gs = '0; gc = '0; ms = '0; mc = '0;
  endtask

  // inputs already driven; one clock, then compare on the falling edge
  task automatic step(input string tag);
    logic [N-1:0] exp, rise;
    exp    = expect_mask();
    rise   = lvl & ~m_prev & m_edge;
    m_pend = ps | rise | (m_pend & ~pc);
    m_edge = es | (m_edge & ~ec);
    m_en   = ns | (m_en & ~nc);
    m_act  = as_ | (m_act & ~ac);
    m_grp  = gs | (m_grp & ~gc);
    m_mod  = ms | (m_mod & ~mc);
    m_prev = lvl;
    @(posedge clk);
    @(negedge clk);
    check(tag, elig, exp);
    clear_pulses();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset", elig, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", elig, '0);

    // R2: level line 0 in group 0
    g0 = 1'b1; ns = 32'h1; step("R2 enable");
    lvl[0] = 1'b1; step("R2 level high");
    step("R2 level held");
    lvl[0] = 1'b0; step("R2 level low");
    step("R2 nothing latched");

    // R3: edge line 1
    es = 32'h2; ns = 32'h2; step("R3 cfg edge");
    lvl[1] = 1'b1; step("R3 rise");
    lvl[1] = 1'b0; step("R3 latch visible");
    step("R3 latch held");

    // R4: clear, then set beats clear
    pc = 32'h2; step("R4 clear");
    step("R4 cleared");
    ps = 32'h2; pc = 32'h2; step("R4 set wins");
    step("R4 still set");
    pc = 32'h2; lvl[1] = 1'b1; step("R4 edge beats clear");
    step("R4 edge result");
    lvl[1] = 1'b0;

    // R5 and R6
    nc = 32'h2; step("R5 disable");
    step("R5 disabled");
    ns = 32'h2; step("R5 re-enable");
    as_ = 32'h2; step("R6 active set");
    step("R6 active masks");
    ac = 32'h2; step("R6 active clear");
    step("R6 restored");

    // R7, R8, R9, R10 on lines 4..6 with pending set
    ps = 32'h70; ns = 32'h70; gs = 32'h10; ms = 32'h20; step("R7 setup");
    g0 = 1'b0; step("R9 g0 off");
    step("R9 g0 off held");
    g1ns = 1'b1; step("R7 g1ns on");
    step("R7 g1ns held");
    g1ns = 1'b0; g1s = 1'b1; step("R8 g1s on");
    step("R8 g1s held");
    soff = 1'b1; step("R10 sec off");
    step("R10 modifier zero");
    g1s = 1'b0; g0 = 1'b1; step("R10 g0 under sec off");
    step("R10 g0 held");
    soff = 1'b0; step("R10 modifier kept");
    step("R9 g0 back");

    // R12: set and clear together on config registers
    es = 32'h100; ec = 32'h100; ns = 32'h100; nc = 32'h100;
    gs = 32'h100; gc = 32'h100; step("R12 set wins");
    ps = 32'h100; step("R12 effect");
    step("R12 held");

    // R11: random traffic
    for (int i = 0; i < 4000; i++) begin
      lvl = lvl ^ ($urandom & $urandom & $urandom);
      ps = $urandom & $urandom & $urandom; pc = $urandom & $urandom & $urandom;
      es = $urandom & $urandom & $urandom; ec = $urandom & $urandom & $urandom;
      ns = $urandom & $urandom; nc = $urandom & $urandom & $urandom;
      as_ = $urandom & $urandom & $urandom & $urandom; ac = $urandom & $urandom;
      gs = $urandom & $urandom & $urandom; gc = $urandom & $urandom & $urandom;
      ms = $urandom & $urandom & $urandom; mc = $urandom & $urandom & $urandom;
      if (($urandom % 8) == 0) begin
        g0 = $urandom; g1s = $urandom; g1ns = $urandom; soff = $urandom;
      end
      step("R11 random");
    end

    finish_run();
  end

endmodule